// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire serial analog-to-digital converter. It drives the converter's chip select, serial clock and power-down lines, and it receives the converter's data output. A one-cycle start request lowers chip select, which starts a conversion and ends the converter's input acquisition. The controller then holds the serial clock low and waits for the converter to raise a single end-of-conversion bit on the data line. If the converter is slow or absent, a timeout ends the wait.

Once the end-of-conversion bit has been seen, the controller produces serial clock pulses that it derives from the system clock. It captures the data line on each rising edge and assembles a straight-binary result, most significant bit first. It then releases chip select, presents the result with a one-cycle valid strobe, and keeps chip select high for a minimum reacquisition interval before it accepts the next request. The data input passes through a synchronizer. Its level is not used during the first cycles after chip select falls, because the line floats while chip select is high.

Top module: `sadc_reader`

## Requirements
- R1: When `enable` is high and the controller is idle, a `start` pulse drives `adc_cs_n` low and `busy` high on the next clock edge.
- R2: While waiting for end of conversion, `adc_sclk` stays low. `adc_sdo` is read through a two-flop synchronizer, and its level is ignored during the first 2 wait cycles. Without this, a floating-high line carried over from the time `adc_cs_n` was high would look like the end-of-conversion bit.
- R3: After end of conversion is detected, `adc_sclk` runs with a half period of 12 system clocks (about 2.08 MHz at 50 MHz, within the 2.1 MHz limit). It starts low and gives exactly 11 pulses.
- R4: The data line is sampled on each rising `adc_sclk` edge. The first sample is the end-of-conversion bit and is discarded. The next 10 samples form `sample`, MSB first, as an unsigned binary value.
- R5: On the 11th falling edge, `adc_cs_n` rises and `adc_sclk` stays low. `sample` is updated, and `sample_vld` is high for exactly one cycle.
- R6: If end of conversion is not seen within 600 wait cycles (12 us), `timeout_err` pulses for one cycle, `adc_cs_n` rises, `busy` falls and the controller returns to idle.
- R7: After a result, `adc_cs_n` is held high for at least 50 cycles (1 us). A `start` during that interval is ignored.
- R8: `busy` stays high from the accepted start until the cycle in which `sample_vld` or `timeout_err` is raised. A `start` while busy is ignored.
- R9: `adc_shdn_n` follows `enable`, one cycle later. A `start` while `enable` is low is ignored.
- R10: In reset, `adc_cs_n`=1, `adc_sclk`=0, `adc_shdn_n`=0, `busy`=0, `sample_vld`=0, `timeout_err`=0 and `sample`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sampling enable; low powers the converter down |
| start | input | 1 | One-cycle conversion request |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_shdn_n | output | 1 | Active-low power-down to the converter |
| busy | output | 1 | Conversion in progress |
| sample | output | 10 | Last conversion result |
| sample_vld | output | 1 | One-cycle strobe for a new `sample` |
| timeout_err | output | 1 | One-cycle strobe when the end-of-conversion wait expires |

## Verification
The hardest case to reach is the one where the data line is still high from the floating period while chip select has already fallen. In that case a stale synchronized level could be taken for the end-of-conversion bit. The bench's converter model drives the line high whenever chip select is high and low as soon as it sees chip select fall. Every conversion therefore passes through this window, and one conversion uses a zero conversion delay so that the real marker arrives immediately after the blanking cycles. Start pulses placed mid-transfer and right after the valid strobe reach the ignored-request cases. A converter that never answers reaches the timeout.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GUARD = 2'd3
  } sadc_state_e;

  // smallest half period (in system clocks) keeping SCLK at or below the limit
  function automatic int sclk_half_cycles(input int clk_hz, input int sclk_max_hz);
    longint num;
    longint den;
    num = longint'(clk_hz);
    den = 2 * longint'(sclk_max_hz);
    return int'((num + den - 1) / den);
  endfunction

  // nanoseconds to system clock cycles, rounded up
  function automatic int ns_to_cycles(input int ns, input int clk_hz);
    longint prod;
    prod = longint'(ns) * longint'(clk_hz);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int HALF = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HW = $clog2(HALF + 1);

  logic [HW-1:0] half_cnt;
  logic          tick;

  assign tick     = run && (half_cnt == HW'(HALF - 1));
  assign rise_evt = tick && !sclk;
  assign fall_evt = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sclk     <= 1'b0;
    end else if (!run) begin
      half_cnt <= '0;
      sclk     <= 1'b0;
    end else if (tick) begin
      half_cnt <= '0;
      sclk     <= ~sclk;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  AST_SCLK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $past(run)); // R3
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int DATA_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 din,
  output logic [DATA_BITS-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[DATA_BITS-2:0], din};
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCLK_MAX_HZ = 2_100_000,
  parameter int DATA_BITS   = 10,
  parameter int TIMEOUT_NS  = 12_000,
  parameter int REACQ_NS    = 1_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 start,
  input  logic                 adc_sdo,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  output logic                 adc_shdn_n,
  output logic                 busy,
  output logic [DATA_BITS-1:0] sample,
  output logic                 sample_vld,
  output logic                 timeout_err
);
  localparam int HALF      = sclk_half_cycles(CLK_HZ, SCLK_MAX_HZ);
  localparam int TMO_CYC   = ns_to_cycles(TIMEOUT_NS, CLK_HZ);
  localparam int REACQ_CYC = ns_to_cycles(REACQ_NS, CLK_HZ);
  localparam int PULSES    = DATA_BITS + 1;
  localparam int TW        = $clog2(TMO_CYC + 1);
  localparam int GW        = $clog2(REACQ_CYC + 1);
  localparam int PW        = $clog2(PULSES + 1);

  sadc_state_e          state;
  logic [TW-1:0]        tmo_cnt;
  logic [GW-1:0]        guard_cnt;
  logic [PW-1:0]        pulse_cnt;
  logic                 sdo_s;
  logic                 rise_evt;
  logic                 fall_evt;
  logic                 run;
  logic [DATA_BITS-1:0] word;

  // named internal events
  logic start_ok;
  logic eoc_seen;
  logic tmo_hit;
  logic last_fall;
  logic guard_done;

  assign run        = (state == ST_SHIFT);
  assign start_ok   = (state == ST_IDLE) && start && enable;
  assign eoc_seen   = (state == ST_WAIT) && (tmo_cnt >= TW'(SYNC_STAGES)) && sdo_s;
  assign tmo_hit    = (state == ST_WAIT) && (tmo_cnt == TW'(TMO_CYC - 1));
  assign last_fall  = fall_evt && (pulse_cnt == PW'(PULSES - 1));
  assign guard_done = (state == ST_GUARD) && (guard_cnt == GW'(REACQ_CYC - 1));

  sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (adc_sdo),
    .dout (sdo_s)
  );

  sadc_sclk_gen #(.HALF(HALF)) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sclk    (adc_sclk),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  sadc_capture #(.DATA_BITS(DATA_BITS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(rise_evt),
    .din     (sdo_s),
    .word    (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adc_shdn_n <= 1'b0;
    else        adc_shdn_n <= enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      adc_cs_n    <= 1'b1;
      busy        <= 1'b0;
      sample      <= '0;
      sample_vld  <= 1'b0;
      timeout_err <= 1'b0;
      tmo_cnt     <= '0;
      guard_cnt   <= '0;
      pulse_cnt   <= '0;
    end else begin
      sample_vld  <= 1'b0;
      timeout_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state    <= ST_WAIT;
            adc_cs_n <= 1'b0;
            busy     <= 1'b1;
            tmo_cnt  <= '0;
          end
        end
        ST_WAIT: begin
          if (eoc_seen) begin
            state     <= ST_SHIFT;
            pulse_cnt <= '0;
          end else if (tmo_hit) begin
            state       <= ST_IDLE;
            timeout_err <= 1'b1;
            adc_cs_n    <= 1'b1;
            busy        <= 1'b0;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last_fall) begin
            state      <= ST_GUARD;
            sample     <= word;
            sample_vld <= 1'b1;
            adc_cs_n   <= 1'b1;
            busy       <= 1'b0;
            guard_cnt  <= '0;
          end else if (fall_evt) begin
            pulse_cnt <= pulse_cnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (guard_done) state <= ST_IDLE;
          else            guard_cnt <= guard_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CS_FALL_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !$past(busy)); // R1
  AST_SCLK_LOW_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !adc_sclk); // R2
  AST_CS_HIGH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk); // R5
  AST_VLD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld); // R5
  AST_ERR_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (adc_cs_n && !busy)); // R6
  AST_GUARD_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUARD) |=> adc_cs_n); // R7
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld || timeout_err) |-> !busy); // R8
endmodule

// File: tb/test_sadc_reader.sv
module test_sadc_reader;
  localparam int CLK_HZ = 50_000_000;
  localparam int SMAX   = 2_100_000;

  // bench restatement of the derived timing
  function automatic int find_half();
    for (int h = 1; h < 1000; h++)
      if (longint'(CLK_HZ) <= longint'(SMAX) * 2 * h) return h;
    return 1000;
  endfunction
  localparam int HALF  = find_half();
  localparam int TMO   = 12_000 / 20;
  localparam int REACQ = 1_000 / 20;

  logic clk = 0, rst_n = 0, enable = 0, start = 0, adc_sdo = 1;
  logic adc_cs_n, adc_sclk, adc_shdn_n, busy, sample_vld, timeout_err;
  logic [9:0] sample;

  always #10 clk = ~clk;

  sadc_reader i_sadc_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .adc_sdo(adc_sdo),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_shdn_n(adc_shdn_n), .busy(busy),
    .sample(sample), .sample_vld(sample_vld), .timeout_err(timeout_err)
  );

  int n_chk = 0, n_bad = 0;

  // ---------------- converter model ----------------
  int         adc_delay = 10;
  logic [9:0] adc_word  = '0;
  int         adc_cnt, adc_idx;
  bit         adc_on = 0;
  logic       p_sclk = 0;
  logic [9:0] exp_q[$];

  always @(negedge clk) begin
    if (adc_cs_n) begin
      adc_sdo = 1'b1;            // floating line reads high
      adc_on  = 0;
      adc_idx = -1;
    end else if (!adc_on) begin
      adc_on  = 1;
      adc_cnt = adc_delay;
      adc_sdo = (adc_delay == 0);
    end else begin
      if (adc_idx < 0 && !adc_sdo && adc_delay >= 0) begin
        if (adc_cnt > 0) adc_cnt--;
        if (adc_cnt == 0) adc_sdo = 1'b1;
      end
      if (p_sclk && !adc_sclk) begin
        adc_idx++;
        adc_sdo = (adc_idx <= 9) ? adc_word[9 - adc_idx] : 1'b0;
      end
    end
    p_sclk = adc_sclk;
  end

  // ---------------- cycle reference model ----------------
  int   m_mode = 0, m_t = 0, m_cap = 0;
  logic e_cs = 1, e_sclk = 0, e_busy = 0, e_vld = 0, e_err = 0, e_shdn = 0;
  logic [9:0] e_res = '0;
  logic hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_cap = 0;
      e_cs = 1; e_sclk = 0; e_busy = 0; e_vld = 0; e_err = 0; e_shdn = 0; e_res = '0;
      hist.delete();
    end else begin
      logic synced;
      synced = (hist.size() >= 2) ? hist[1] : 1'b0;
      e_vld = 0; e_err = 0;
      e_shdn = enable;
      case (m_mode)
        0: if (start && enable) begin m_mode = 1; m_t = 0; e_cs = 0; e_busy = 1; end
        1: begin
          if (m_t >= 2 && synced) begin m_mode = 2; m_t = 0; end
          else if (m_t == TMO - 1) begin
            e_err = 1; e_cs = 1; e_busy = 0; m_mode = 0;
          end else m_t++;
        end
        2: begin
          if (m_t % HALF == HALF - 1) begin
            int n;
            n = (m_t + 1) / HALF;
            if (n % 2 == 1) begin
              e_sclk = 1;
              m_cap = (m_cap * 2 + int'(synced)) % 2048;
            end else begin
              e_sclk = 0;
              if (n == 22) begin
                e_res = 10'(m_cap % 1024); e_vld = 1; e_cs = 1; e_busy = 0;
                m_mode = 3; m_t = -1;
              end
            end
          end
          m_t++;
        end
        default: begin
          if (m_t == REACQ - 1) m_mode = 0; else m_t++;
        end
      endcase
      hist.push_front(adc_sdo);
      if (hist.size() > 2) void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R10", "cs_n", adc_cs_n, 1);   chk("R10", "sclk", adc_sclk, 0);
      chk("R10", "busy", busy, 0);       chk("R10", "vld", sample_vld, 0);
      chk("R10", "err", timeout_err, 0); chk("R10", "shdn_n", adc_shdn_n, 0);
      chk("R10", "sample", sample, 0);
    end else begin
      chk(m_mode == 3 ? "R7" : "R1", "cs_n", adc_cs_n, e_cs);
      chk(m_mode == 1 ? "R2" : "R3", "sclk", adc_sclk, e_sclk);
      chk("R8", "busy", busy, e_busy);
      chk("R5", "vld", sample_vld, e_vld);
      chk("R6", "err", timeout_err, e_err);
      chk("R9", "shdn_n", adc_shdn_n, e_shdn);
      chk("R4", "sample", sample, e_res);
      if (sample_vld) begin
        if (exp_q.size() == 0) chk("R4", "unexpected_result", 1, 0);
        else chk("R4", "word", sample, exp_q.pop_front());
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (m_mode != 0 && guard < 5000);
    repeat (3) @(negedge clk);
  endtask

  task automatic convert(input logic [9:0] w, input int dly);
    adc_word = w; adc_delay = dly; exp_q.push_back(w);
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9: start ignored while disabled
    pulse_start();
    repeat (5) @(negedge clk);
    enable = 1;
    repeat (3) @(negedge clk);
    convert(10'h2A5, 450);
    convert(10'h000, 30);
    convert(10'h3FF, 0);      // R2: marker right after blanking
    convert(10'h200, 5);
    // R8: start during transfer ignored
    adc_word = 10'h155; adc_delay = 20; exp_q.push_back(10'h155);
    pulse_start();
    repeat (150) @(negedge clk);
    pulse_start();
    // R7: start right after the strobe ignored
    do @(negedge clk); while (!sample_vld);
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    pulse_start();
    wait_idle();
    convert(10'h001, 100);
    // R6: converter never answers
    adc_delay = -1;
    pulse_start();
    wait_idle();
    convert(10'h0F0, 12);
    chk("R4", "results_left", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule